// File: doc/BRIEF.md
# Compressed Instruction Expander

This block turns a 16-bit compressed instruction into the matching 32-bit base-ISA word. A fetch stage that already has a full-width decoder can then run compressed code without a second decoder. The expander is purely combinational. It moves register indices into their wide-format fields, scales offsets to the unit the wide format counts in, and picks a fixed base opcode for every encoding. Every word it produces carries the always-execute condition in bits [31:28].

A separate unit executes branch-class encodings: conditional branches, the unconditional branch and both halves of the two-halfword call. The expander only marks these with a "handled elsewhere" flag. One input enables the v5 extensions: register branch-with-link-exchange, the breakpoint, and the second half of the call in its exchange form. When that input is low, those encodings are undefined. Whenever the output word is not usable, the block drives a fixed placeholder instead.

Top module: `cx_expander`

## Requirements
- R1: Bits [15:11] select the format. Values 0 to 2 yield 0xE1B00000 with bits [12:11] placed at [6:5], bits [10:6] at [11:7], bits [5:3] at [2:0] and bits [2:0] at [15:12].
- R2: Value 3 ORs a base chosen by bits [10:9] (00 0xE0900000, 01 0xE0500000, 10 0xE2900000, 11 0xE2500000) with bits [8:6] at [2:0], bits [5:3] at [19:16] and bits [2:0] at [15:12].
- R3: Values 4 to 7 OR a base chosen by bits [12:11] (0xE3B00000, 0xE3500000, 0xE2900000, 0xE2500000) with the 8-bit immediate in [7:0] and bits [10:8] copied into both [19:16] and [15:12].
- R4: Value 8 with bit 10 clear is the ALU group. Bits [9:6] pick one of 16 bases, and each base uses one of four operand placements. With rd = bits [2:0] and rs = bits [5:3]:
  - normal: rd at [19:16] and [15:12], rs at [2:0]
  - shift: rd at [15:12] and [2:0], rs at [11:8]
  - negate (0xE2700000): rd at [15:12], rs at [19:16]
  - multiply (0xE0100090): rd at [19:16] and [11:8], rs at [2:0]
- R5: Value 8 with bit 10 set is the high-register group. The destination index is {bit 7, bits [2:0]} and the source index is {bit 6, bits [5:3]}. Sub-op bits [9:8] 00, 01 and 10 give 0xE0800000, 0xE1500000 and 0xE1A00000, ORed with the destination at [19:16] and [15:12] and the source at [3:0]. Sub-ops 0xC and 0xD give 0xE12FFF10 | bits [6:3]. Sub-ops 0, 4 and 8 are undefined.
- R6: With the v5 input high, sub-ops 0xE and 0xF of the high-register group give 0xE12FFF30 | bits [6:3], and field [11:8] = 0xE in the stack group gives 0xE1200070 | (bits [7:4] << 8) | bits [3:0]. With the v5 input low, both are undefined.
- R7: PC- and SP-based forms scale the 8-bit immediate as follows:
  - value 9: 0xE59F0000, rd = bits [10:8] at [15:12], immediate << 2
  - values 18 and 19: 0xE58D0000 (store) or 0xE59D0000 (load, bit 11), rd at [15:12], immediate << 2
  - values 20 and 21: 0xE28F0F00 (bit 11 clear) or 0xE28D0F00, rd at [15:12], immediate unshifted in [7:0]
- R8: Values 10 and 11 are register-offset transfers. Bits [11:10] pick the base: 0xE7800000, 0xE7C00000, 0xE7900000, 0xE7D00000 when bit 9 is clear, and 0xE18000B0, 0xE19000D0, 0xE19000B0, 0xE19000F0 when bit 9 is set. The base is ORed with bits [2:0] at [15:12], bits [5:3] at [19:16] and bits [8:6] at [2:0].
- R9: Values 12 to 15 OR a base chosen by bits [12:11] (0xE5800000, 0xE5900000, 0xE5C00000, 0xE5D00000) with rd at [15:12] and rb at [19:16]. The 5-bit offset in bits [10:6] is shifted left by 2 for word accesses and unshifted for byte accesses (bit 12 set).
- R10: Values 16 and 17 use 0xE1C000B0 (store) or 0xE1D000B0 (load, bit 11), with rd at [15:12] and rb at [19:16]. The doubled 5-bit offset is split: bits [8:6] go to [3:1] and bits [10:9] go to [9:8].
- R11: The stack group (values 22 and 23) is decoded on field [11:8]:
  - 0x4: 0xE92D0000 | mask; 0x5: 0xE92D4000 | mask
  - 0xC: 0xE8BD0000 | mask; 0xD: 0xE8BD8000 | mask
  - 0x0: 0xE28DDF00, or 0xE24DDF00 when bit 7 is set, ORed with bits [6:0]
  - any other value (apart from the v5 breakpoint of R6) is undefined.

  Values 24 and 25 give 0xE8A00000 (store) or 0xE8B00000 (load, bit 11), with bits [10:8] at [19:16] and the mask in [7:0].
- R12: The following raise the branch flag:
  - values 26 and 27 with field [11:8] below 0xE
  - values 28, 30 and 31
  - value 29 with the v5 input high and bit 0 clear

  Field 0xE in values 26 and 27 is undefined, and value 29 is undefined otherwise. Field 0xF is a software interrupt: 0xEF000000 | bits [7:0], valid.
- R13: Exactly one of valid, undefined and branch is high for any input. Whenever valid is low, the output word is 0xE7F000F0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr_hw | input | 16 | Compressed instruction halfword |
| ext_v5 | input | 1 | Enables the v5 extension encodings |
| word_out | output | 32 | Expanded base-ISA word, or the placeholder |
| word_ok | output | 1 | word_out holds a usable expansion |
| is_undef | output | 1 | Encoding is undefined |
| is_branch | output | 1 | Branch-class encoding, executed elsewhere |

## Verification
The bench targets the corners where a single field slip still yields a plausible word:
- Multiply and negate use placements different from the other ALU entries, so a design that shared one placement would swap register fields.
- Byte and word immediates scale differently, so a missing scale select would return offsets four times too large or too small.
- The halfword offset is split across two nibbles, which a misrouted bit would corrupt.
- The high-register sub-ops 0, 4 and 8 must be undefined, or they would pass through as low-register adds or moves.
- The v5 gate is tested with both values of the enable, so a leaky gate shows up as a breakpoint or call word produced with the extensions off.
- The conditional-branch field value 0xE must be undefined, not flagged as a branch.

// File: rtl/cx_pkg.sv
package cx_pkg;

    localparam int HW_W   = 16;
    localparam int WD_W   = 32;
    localparam int FMT_W  = 5;
    localparam int FMT_LO = HW_W - FMT_W;

    typedef struct packed {
        logic [WD_W-1:0] word;
        logic            ok;
        logic            undef;
        logic            brn;
    } xp_res_t;

    typedef enum logic [1:0] {
        PL_NORM,
        PL_SHIFT,
        PL_NEG,
        PL_MUL
    } alu_place_e;

    function automatic xp_res_t mk_ok(input logic [WD_W-1:0] w);
        xp_res_t r;
        r.word  = w;
        r.ok    = 1'b1;
        r.undef = 1'b0;
        r.brn   = 1'b0;
        return r;
    endfunction

    function automatic xp_res_t mk_undef();
        xp_res_t r;
        r.word  = '0;
        r.ok    = 1'b0;
        r.undef = 1'b1;
        r.brn   = 1'b0;
        return r;
    endfunction

    function automatic xp_res_t mk_brn();
        xp_res_t r;
        r.word  = '0;
        r.ok    = 1'b0;
        r.undef = 1'b0;
        r.brn   = 1'b1;
        return r;
    endfunction

endpackage

// File: rtl/cx_alu_grp.sv
module cx_alu_grp
    import cx_pkg::*;
(
    input  logic [HW_W-1:0] hw,
    input  logic            v5_en,
    output xp_res_t         res
);

    logic [FMT_W-1:0] fmt;
    logic [2:0]       f_lo;
    logic [2:0]       f_mid;
    logic [2:0]       f_hi;
    logic [2:0]       f_top;
    logic [3:0]       alu_op;
    logic [3:0]       hd_idx;
    logic [3:0]       hs_idx;
    logic [WD_W-1:0]  alu_base;
    alu_place_e       alu_pl;
    logic [WD_W-1:0]  hi_base;

    assign fmt    = hw[HW_W-1:FMT_LO];
    assign f_lo   = hw[2:0];
    assign f_mid  = hw[5:3];
    assign f_hi   = hw[8:6];
    assign f_top  = hw[10:8];
    assign alu_op = hw[9:6];
    assign hd_idx = {hw[7], hw[2:0]};
    assign hs_idx = {hw[6], hw[5:3]};

    // ALU group: base opcode and operand placement per sub-op
    always_comb begin
        alu_pl = PL_NORM;
        case (alu_op)
            4'h0: alu_base = 32'hE010_0000;
            4'h1: alu_base = 32'hE030_0000;
            4'h2: begin alu_base = 32'hE1B0_0010; alu_pl = PL_SHIFT; end
            4'h3: begin alu_base = 32'hE1B0_0030; alu_pl = PL_SHIFT; end
            4'h4: begin alu_base = 32'hE1B0_0050; alu_pl = PL_SHIFT; end
            4'h5: alu_base = 32'hE0B0_0000;
            4'h6: alu_base = 32'hE0D0_0000;
            4'h7: begin alu_base = 32'hE1B0_0070; alu_pl = PL_SHIFT; end
            4'h8: alu_base = 32'hE110_0000;
            4'h9: begin alu_base = 32'hE270_0000; alu_pl = PL_NEG; end
            4'hA: alu_base = 32'hE150_0000;
            4'hB: alu_base = 32'hE170_0000;
            4'hC: alu_base = 32'hE190_0000;
            4'hD: begin alu_base = 32'hE010_0090; alu_pl = PL_MUL; end
            4'hE: alu_base = 32'hE1D0_0000;
            default: alu_base = 32'hE1F0_0000;
        endcase
    end

    always_comb begin
        case (alu_op[3:2])
            2'b00:   hi_base = 32'hE080_0000;
            2'b01:   hi_base = 32'hE150_0000;
            default: hi_base = 32'hE1A0_0000;
        endcase
    end

    always_comb begin
        res = mk_undef();
        case (fmt)
            5'd0, 5'd1, 5'd2: begin
                res = mk_ok(32'hE1B0_0000
                            | (WD_W'(hw[12:11]) << 5)
                            | (WD_W'(hw[10:6])  << 7)
                            |  WD_W'(f_mid)
                            | (WD_W'(f_lo)      << 12));
            end
            5'd3: begin
                logic [WD_W-1:0] b3;
                case (hw[10:9])
                    2'b00:   b3 = 32'hE090_0000;
                    2'b01:   b3 = 32'hE050_0000;
                    2'b10:   b3 = 32'hE290_0000;
                    default: b3 = 32'hE250_0000;
                endcase
                res = mk_ok(b3 | WD_W'(f_hi)
                               | (WD_W'(f_mid) << 16)
                               | (WD_W'(f_lo)  << 12));
            end
            5'd4, 5'd5, 5'd6, 5'd7: begin
                logic [WD_W-1:0] b4;
                case (hw[12:11])
                    2'b00:   b4 = 32'hE3B0_0000;
                    2'b01:   b4 = 32'hE350_0000;
                    2'b10:   b4 = 32'hE290_0000;
                    default: b4 = 32'hE250_0000;
                endcase
                res = mk_ok(b4 | WD_W'(hw[7:0])
                               | (WD_W'(f_top) << 16)
                               | (WD_W'(f_top) << 12));
            end
            5'd8: begin
                if (!hw[10]) begin
                    case (alu_pl)
                        PL_NORM:  res = mk_ok(alu_base | (WD_W'(f_lo) << 16)
                                              | (WD_W'(f_lo) << 12) | WD_W'(f_mid));
                        PL_SHIFT: res = mk_ok(alu_base | (WD_W'(f_lo) << 12)
                                              | WD_W'(f_lo) | (WD_W'(f_mid) << 8));
                        PL_NEG:   res = mk_ok(alu_base | (WD_W'(f_lo) << 12)
                                              | (WD_W'(f_mid) << 16));
                        default:  res = mk_ok(alu_base | (WD_W'(f_lo) << 16)
                                              | (WD_W'(f_lo) << 8) | WD_W'(f_mid));
                    endcase
                end else if (alu_op[3:2] == 2'b11) begin
                    if (!alu_op[1])
                        res = mk_ok(32'hE12F_FF10 | WD_W'(hw[6:3]));
                    else if (v5_en)
                        res = mk_ok(32'hE12F_FF30 | WD_W'(hw[6:3]));
                    else
                        res = mk_undef();
                end else if (alu_op[1:0] == 2'b00) begin
                    res = mk_undef();
                end else begin
                    res = mk_ok(hi_base | (WD_W'(hd_idx) << 16)
                                        | (WD_W'(hd_idx) << 12)
                                        |  WD_W'(hs_idx));
                end
            end
            default: res = mk_undef();
        endcase
    end

endmodule

// File: rtl/cx_ldst_grp.sv
module cx_ldst_grp
    import cx_pkg::*;
(
    input  logic [HW_W-1:0] hw,
    output xp_res_t         res
);

    logic [FMT_W-1:0] fmt;
    logic [2:0]       f_lo;
    logic [2:0]       f_mid;
    logic [2:0]       f_hi;
    logic [2:0]       f_top;
    logic [7:0]       imm8;
    logic [4:0]       imm5;
    logic [WD_W-1:0]  rd_at12;
    logic [WD_W-1:0]  rb_at16;
    logic [WD_W-1:0]  top_at12;

    assign fmt      = hw[HW_W-1:FMT_LO];
    assign f_lo     = hw[2:0];
    assign f_mid    = hw[5:3];
    assign f_hi     = hw[8:6];
    assign f_top    = hw[10:8];
    assign imm8     = hw[7:0];
    assign imm5     = hw[10:6];
    assign rd_at12  = WD_W'(f_lo)  << 12;
    assign rb_at16  = WD_W'(f_mid) << 16;
    assign top_at12 = WD_W'(f_top) << 12;

    always_comb begin
        res = mk_undef();
        case (fmt)
            5'd9: begin
                res = mk_ok(32'hE59F_0000 | top_at12 | (WD_W'(imm8) << 2));
            end
            5'd10, 5'd11: begin
                logic [WD_W-1:0] br;
                if (!hw[9]) begin
                    case (hw[11:10])
                        2'b00:   br = 32'hE780_0000;
                        2'b01:   br = 32'hE7C0_0000;
                        2'b10:   br = 32'hE790_0000;
                        default: br = 32'hE7D0_0000;
                    endcase
                end else begin
                    case (hw[11:10])
                        2'b00:   br = 32'hE180_00B0;
                        2'b01:   br = 32'hE190_00D0;
                        2'b10:   br = 32'hE190_00B0;
                        default: br = 32'hE190_00F0;
                    endcase
                end
                res = mk_ok(br | rd_at12 | rb_at16 | WD_W'(f_hi));
            end
            5'd12, 5'd13, 5'd14, 5'd15: begin
                logic [WD_W-1:0] bi;
                logic [WD_W-1:0] off;
                case (hw[12:11])
                    2'b00:   bi = 32'hE580_0000;
                    2'b01:   bi = 32'hE590_0000;
                    2'b10:   bi = 32'hE5C0_0000;
                    default: bi = 32'hE5D0_0000;
                endcase
                off = hw[12] ? WD_W'(imm5) : (WD_W'(imm5) << 2);
                res = mk_ok(bi | rd_at12 | rb_at16 | off);
            end
            5'd16, 5'd17: begin
                res = mk_ok((hw[11] ? 32'hE1D0_00B0 : 32'hE1C0_00B0)
                            | rd_at12 | rb_at16
                            | (WD_W'(imm5[2:0]) << 1)
                            | (WD_W'(imm5[4:3]) << 8));
            end
            5'd18, 5'd19: begin
                res = mk_ok((hw[11] ? 32'hE59D_0000 : 32'hE58D_0000)
                            | top_at12 | (WD_W'(imm8) << 2));
            end
            5'd20, 5'd21: begin
                res = mk_ok((hw[11] ? 32'hE28D_0F00 : 32'hE28F_0F00)
                            | top_at12 | WD_W'(imm8));
            end
            5'd24, 5'd25: begin
                res = mk_ok((hw[11] ? 32'hE8B0_0000 : 32'hE8A0_0000)
                            | (WD_W'(f_top) << 16) | WD_W'(imm8));
            end
            default: res = mk_undef();
        endcase
    end

endmodule

// File: rtl/cx_ctl_grp.sv
module cx_ctl_grp
    import cx_pkg::*;
(
    input  logic [HW_W-1:0] hw,
    input  logic            v5_en,
    output xp_res_t         res
);

    logic [FMT_W-1:0] fmt;
    logic [3:0]       sub;
    logic [7:0]       imm8;

    assign fmt  = hw[HW_W-1:FMT_LO];
    assign sub  = hw[11:8];
    assign imm8 = hw[7:0];

    always_comb begin
        res = mk_undef();
        case (fmt)
            5'd22, 5'd23: begin
                case (sub)
                    4'h0: res = mk_ok((hw[7] ? 32'hE24D_DF00 : 32'hE28D_DF00)
                                      | WD_W'(hw[6:0]));
                    4'h4: res = mk_ok(32'hE92D_0000 | WD_W'(imm8));
                    4'h5: res = mk_ok(32'hE92D_4000 | WD_W'(imm8));
                    4'hC: res = mk_ok(32'hE8BD_0000 | WD_W'(imm8));
                    4'hD: res = mk_ok(32'hE8BD_8000 | WD_W'(imm8));
                    4'hE: begin
                        if (v5_en)
                            res = mk_ok(32'hE120_0070 | (WD_W'(hw[7:4]) << 8)
                                        | WD_W'(hw[3:0]));
                        else
                            res = mk_undef();
                    end
                    default: res = mk_undef();
                endcase
            end
            5'd26, 5'd27: begin
                if (sub == 4'hF)
                    res = mk_ok(32'hEF00_0000 | WD_W'(imm8));
                else if (sub == 4'hE)
                    res = mk_undef();
                else
                    res = mk_brn();
            end
            5'd28, 5'd30, 5'd31: res = mk_brn();
            5'd29: begin
                if (v5_en && !hw[0])
                    res = mk_brn();
                else
                    res = mk_undef();
            end
            default: res = mk_undef();
        endcase
    end

endmodule

// File: rtl/cx_expander.sv
module cx_expander
    import cx_pkg::*;
#(
    parameter logic [31:0] UNDEF_WORD = 32'hE7F0_00F0
) (
    input  logic [15:0] instr_hw,
    input  logic        ext_v5,
    output logic [31:0] word_out,
    output logic        word_ok,
    output logic        is_undef,
    output logic        is_branch
);

    localparam logic [FMT_W-1:0] ALU_LAST  = 5'd8;
    localparam logic [FMT_W-1:0] LDST_LAST = 5'd21;

    logic [FMT_W-1:0] fmt;
    xp_res_t          alu_res;
    xp_res_t          ldst_res;
    xp_res_t          ctl_res;
    xp_res_t          res_d;

    assign fmt = instr_hw[HW_W-1:FMT_LO];

    cx_alu_grp u_alu (
        .hw    (instr_hw),
        .v5_en (ext_v5),
        .res   (alu_res)
    );

    cx_ldst_grp u_ldst (
        .hw  (instr_hw),
        .res (ldst_res)
    );

    cx_ctl_grp u_ctl (
        .hw    (instr_hw),
        .v5_en (ext_v5),
        .res   (ctl_res)
    );

    always_comb begin
        if (fmt <= ALU_LAST)
            res_d = alu_res;
        else if (fmt <= LDST_LAST || fmt == 5'd24 || fmt == 5'd25)
            res_d = ldst_res;
        else
            res_d = ctl_res;
        if (!res_d.ok)
            res_d.word = UNDEF_WORD;
    end

    assign word_out  = res_d.word;
    assign word_ok   = res_d.ok;
    assign is_undef  = res_d.undef;
    assign is_branch = res_d.brn;

endmodule

// File: rtl/cx_expander_chk.sv
module cx_expander_chk #(
    parameter logic [31:0] UNDEF_WORD = 32'hE7F0_00F0
) (
    input logic [15:6] hw_hi,
    input logic        ext_v5,
    input logic [31:0] word_out,
    input logic        word_ok,
    input logic        is_undef,
    input logic        is_branch
);

    always_comb begin
        if (!$isunknown({hw_hi, ext_v5, word_out, word_ok, is_undef, is_branch})) begin
            // R13
            flags_onehot_chk: assert ($onehot({word_ok, is_undef, is_branch}));
            // R13
            placeholder_chk: assert (word_ok || word_out == UNDEF_WORD);
            // R13
            always_cond_chk: assert (!word_ok || word_out[31:28] == 4'hE);
            // R12
            cond_branch_chk: assert (!(hw_hi[15:12] == 4'hD && hw_hi[11:9] != 3'b111)
                                     || is_branch);
            // R6
            v5_gate_chk: assert (!(!ext_v5 && hw_hi[15:10] == 6'b010001
                                   && hw_hi[9:7] == 3'b111) || is_undef);
            // R5
            hi_undef_chk: assert (!(hw_hi[15:10] == 6'b010001 && hw_hi[7:6] == 2'b00
                                    && hw_hi[9:8] != 2'b11) || is_undef);
        end
    end

endmodule

bind cx_expander cx_expander_chk #(.UNDEF_WORD(UNDEF_WORD)) u_chk (
    .hw_hi     (instr_hw[15:6]),
    .ext_v5    (ext_v5),
    .word_out  (word_out),
    .word_ok   (word_ok),
    .is_undef  (is_undef),
    .is_branch (is_branch)
);

// File: tb/sim_cx_expander.sv
module sim_cx_expander;

    localparam int          CLK_PERIOD = 10;
    localparam logic [31:0] PH         = 32'hE7F0_00F0;
    localparam int          K_OK       = 0;
    localparam int          K_UND      = 1;
    localparam int          K_BRN      = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] instr_hw = '0;
    logic        ext_v5 = 1'b0;
    logic [31:0] word_out;
    logic        word_ok;
    logic        is_undef;
    logic        is_branch;

    int n_run  = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cx_expander u0 (
        .instr_hw  (instr_hw),
        .ext_v5    (ext_v5),
        .word_out  (word_out),
        .word_ok   (word_ok),
        .is_undef  (is_undef),
        .is_branch (is_branch)
    );

    task automatic chk(input string req, input logic [15:0] hw, input logic v5,
                       input int kind, input logic [31:0] exp_w);
        logic [31:0] ew;
        logic [2:0]  ef;
        @(posedge clk);
        instr_hw = hw;
        ext_v5   = v5;
        @(negedge clk);
        ew = (kind == K_OK) ? exp_w : PH;
        ef = (kind == K_OK) ? 3'b100 : (kind == K_UND) ? 3'b010 : 3'b001;
        n_run++;
        if (word_out !== ew || {word_ok, is_undef, is_branch} !== ef) begin
            n_fail++;
            $display("FAIL %s hw=%h v5=%0d actual word=%h flags=%b expected word=%h flags=%b",
                     req, hw, v5, word_out, {word_ok, is_undef, is_branch}, ew, ef);
        end
    endtask

    task automatic t_reset;
        chk("R1 reset", 16'h0000, 1'b0, K_OK, 32'hE1B0_0000);
    endtask

    task automatic t_shift_imm;
        chk("R1", 16'h0151, 1'b0, K_OK, 32'hE1B0_1282);
        chk("R1", 16'h17C7, 1'b0, K_OK, 32'hE1B0_7FC0);
    endtask

    task automatic t_addsub3;
        chk("R2", 16'h1FA3, 1'b0, K_OK, 32'hE254_3006);
        chk("R2", 16'h1888, 1'b0, K_OK, 32'hE091_0002);
    endtask

    task automatic t_imm8;
        chk("R3", 16'h2DA7, 1'b0, K_OK, 32'hE355_50A7);
        chk("R3", 16'h22FF, 1'b0, K_OK, 32'hE3B2_20FF);
    endtask

    task automatic t_alu;
        chk("R4 mul", 16'h4373, 1'b0, K_OK, 32'hE013_0396);
        chk("R4 neg", 16'h426A, 1'b0, K_OK, 32'hE275_2000);
        chk("R4 ror", 16'h41CC, 1'b0, K_OK, 32'hE1B0_4174);
        chk("R4 eor", 16'h4078, 1'b0, K_OK, 32'hE030_0007);
        chk("R4 mvn", 16'h43D1, 1'b0, K_OK, 32'hE1F1_1002);
    endtask

    task automatic t_hireg;
        chk("R5 mov", 16'h46E3, 1'b0, K_OK, 32'hE1AB_B00C);
        chk("R5 add", 16'h446A, 1'b0, K_OK, 32'hE082_200D);
        chk("R5 cmp", 16'h45B9, 1'b0, K_OK, 32'hE159_9007);
        chk("R5 bx", 16'h4770, 1'b0, K_OK, 32'hE12F_FF1E);
        chk("R5 op0", 16'h4400, 1'b1, K_UND, 32'h0);
        chk("R5 op4", 16'h4500, 1'b1, K_UND, 32'h0);
        chk("R5 op8", 16'h4600, 1'b1, K_UND, 32'h0);
    endtask

    task automatic t_v5;
        chk("R6 blx v5", 16'h4798, 1'b1, K_OK, 32'hE12F_FF33);
        chk("R6 blx off", 16'h4798, 1'b0, K_UND, 32'h0);
        chk("R6 bkpt v5", 16'hBEAB, 1'b1, K_OK, 32'hE120_0A7B);
        chk("R6 bkpt off", 16'hBEAB, 1'b0, K_UND, 32'h0);
    endtask

    task automatic t_pcsp;
        chk("R7 pc load", 16'h4E40, 1'b0, K_OK, 32'hE59F_6100);
        chk("R7 sp store", 16'h9103, 1'b0, K_OK, 32'hE58D_100C);
        chk("R7 sp load", 16'h9FFF, 1'b0, K_OK, 32'hE59D_73FC);
        chk("R7 pc addr", 16'hA012, 1'b0, K_OK, 32'hE28F_0F12);
        chk("R7 sp addr", 16'hAD80, 1'b0, K_OK, 32'hE28D_5F80);
    endtask

    task automatic t_regoff;
        chk("R8 ldrb", 16'h5D1A, 1'b0, K_OK, 32'hE7D3_2004);
        chk("R8 ldrsh", 16'h5FC1, 1'b0, K_OK, 32'hE190_10F7);
        chk("R8 strh", 16'h5288, 1'b0, K_OK, 32'hE181_00B2);
    endtask

    task automatic t_immoff;
        chk("R9 word", 16'h67C8, 1'b0, K_OK, 32'hE581_007C);
        chk("R9 byte", 16'h7FEC, 1'b0, K_OK, 32'hE5D5_401F);
    endtask

    task automatic t_half;
        chk("R10 ldrh", 16'h8ED3, 1'b0, K_OK, 32'hE1D2_33B6);
        chk("R10 strh", 16'h8438, 1'b0, K_OK, 32'hE1C7_02B0);
    endtask

    task automatic t_stack;
        chk("R11 push", 16'hB4F0, 1'b0, K_OK, 32'hE92D_00F0);
        chk("R11 push lr", 16'hB501, 1'b0, K_OK, 32'hE92D_4001);
        chk("R11 pop", 16'hBC03, 1'b0, K_OK, 32'hE8BD_0003);
        chk("R11 pop pc", 16'hBD80, 1'b0, K_OK, 32'hE8BD_8080);
        chk("R11 sp add", 16'hB005, 1'b0, K_OK, 32'hE28D_DF05);
        chk("R11 sp sub", 16'hB085, 1'b0, K_OK, 32'hE24D_DF05);
        chk("R11 undef", 16'hB100, 1'b1, K_UND, 32'h0);
        chk("R11 ldm", 16'hCA81, 1'b0, K_OK, 32'hE8B2_0081);
        chk("R11 stm", 16'hC7FF, 1'b0, K_OK, 32'hE8A7_00FF);
    endtask

    task automatic t_branch;
        chk("R12 beq", 16'hD0FE, 1'b0, K_BRN, 32'h0);
        chk("R12 cond c", 16'hDCFF, 1'b0, K_BRN, 32'h0);
        chk("R12 b", 16'hE7FE, 1'b0, K_BRN, 32'h0);
        chk("R12 call hi", 16'hF000, 1'b0, K_BRN, 32'h0);
        chk("R12 call lo", 16'hF800, 1'b0, K_BRN, 32'h0);
        chk("R12 cond e", 16'hDE00, 1'b1, K_UND, 32'h0);
        chk("R12 swi", 16'hDF2A, 1'b0, K_OK, 32'hEF00_002A);
        chk("R12 x29 v5", 16'hE802, 1'b1, K_BRN, 32'h0);
        chk("R12 x29 off", 16'hE802, 1'b0, K_UND, 32'h0);
        chk("R12 x29 odd", 16'hE803, 1'b1, K_UND, 32'h0);
    endtask

    task automatic t_placeholder;
        // R13: flags one-hot and placeholder after a valid word
        chk("R13 valid", 16'h0151, 1'b0, K_OK, 32'hE1B0_1282);
        chk("R13 undef", 16'h4400, 1'b0, K_UND, 32'h0);
        chk("R13 branch", 16'hE000, 1'b0, K_BRN, 32'h0);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL R13 watchdog actual=running expected=finished");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        rst = 1'b0;
        t_reset();
        t_shift_imm();
        t_addsub3();
        t_imm8();
        t_alu();
        t_hireg();
        t_v5();
        t_pcsp();
        t_regoff();
        t_immoff();
        t_half();
        t_stack();
        t_branch();
        t_placeholder();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule